// File: doc/BRIEF.md
# Dual Prescaled Reloadable Timer Unit

This block holds two independent down-counting timers behind a small 32-bit register bus. The first, the real-time timer, divides the clock with an 8-bit prescaler. The second, the general-purpose timer, divides it with a 16-bit prescaler. Each timer has a 32-bit counter, a 32-bit reload value and a prescaler limit. One shared control word sets the mode of both timers in a single write.

A timer decrements once every (limit + 1) clock cycles while it is running. When it is at zero on such a step, it emits a one-cycle interrupt pulse on its own output. It then either copies its reload value into the counter and keeps going, or stops. Software loads and starts a timer through the control word. The counter and reload registers share one address: a read returns the live count and a write stores a new reload value.

Word addresses on `bus_addr`: 0 = real-time count/reload, 1 = real-time prescaler limit, 2 = general-purpose count/reload, 3 = general-purpose prescaler limit, 4 = control (reads as zero). Within the control word, the general-purpose timer decodes bits 3:0 and the real-time timer decodes bits 11:8. In each nibble, bit +0 selects auto-reload, bit +1 loads the counter from the reload value and sets the continue latch, bit +2 enables the prescaler, and bit +3 sets the continue latch without loading.

Top module: `tmr_dual_unit`

## Requirements
- R1: After reset, both counters and both reload values are 0xFFFFFFFF, the real-time limit reads 0xFF, the general-purpose limit reads 0xFFFF, both interrupt outputs are low, and no timer runs.
- R2: A write to a prescaler limit keeps only the low 8 bits (real-time) or the low 16 bits (general-purpose), and a read returns that value zero-extended.
- R3: After a control write that loads value N and enables a timer with limit S, the interrupt pulse appears (N+1)*(S+1) cycles after the write's clock edge, and only while the counter is zero.
- R4: With auto-reload set, successive interrupt pulses of a timer are exactly (R+1)*(S+1) cycles apart, for reload value R.
- R5: With auto-reload clear, a timer gives one pulse at underflow, then stops with its counter holding 0.
- R6: Each interrupt output is high for a single cycle when the underflow period exceeds one cycle.
- R7: Writing a reload value leaves the counter unchanged. The new value reaches the counter at the next load command.
- R8: The start-without-load bit together with enable resumes a stopped timer from its present counter value.
- R9: A counter changes only when the prescaler enable and the continue latch are both set. A load without enable, or an enable without continue, leaves the count frozen.
- R10: The two timers use separate control bits and separate outputs. A running timer never pulses the other timer's output.
- R11: A counter read returns the live value, which falls by one per prescaler period while the timer runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_we | input | 1 | Write strobe for one cycle |
| bus_addr | input | 3 | Word address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| irq_rtc | output | 1 | Real-time timer underflow pulse |
| irq_gpt | output | 1 | General-purpose timer underflow pulse |

## Verification
On every cycle the assertions check several things. An interrupt pulse only follows a zero count. A pulse lasts one cycle whenever the prescaler limit is non-zero. A stopped timer's counter stays frozen unless a control write occurs. A running counter moves only by a single decrement or to its reload value. The reset values are also checked right after reset. Exact latencies and periods, prescaler truncation, resume without load, and the separation of the two timers can only be shown by the bench's scenarios, which count cycles against products computed from the programmed values.

// File: rtl/tmr_pkg.sv
// Package: shared widths, register word addresses and control-nibble layout
// for the dual timer unit. Assumes word-addressed 32-bit registers.
package tmr_pkg;
    localparam int unsigned DATA_W   = 32;
    localparam int unsigned ADDR_W   = 3;
    localparam int unsigned N_TMR    = 2;

    // Register word addresses (channel 0 = real-time, 1 = general-purpose)
    localparam logic [ADDR_W-1:0] REG_RTC_CNT = 3'd0;
    localparam logic [ADDR_W-1:0] REG_RTC_LIM = 3'd1;
    localparam logic [ADDR_W-1:0] REG_GPT_CNT = 3'd2;
    localparam logic [ADDR_W-1:0] REG_GPT_LIM = 3'd3;
    localparam logic [ADDR_W-1:0] REG_CTRL    = 3'd4;

    // Bit offsets inside one timer's control nibble
    localparam int unsigned CTL_AUTO   = 0;
    localparam int unsigned CTL_LOAD   = 1;
    localparam int unsigned CTL_EN     = 2;
    localparam int unsigned CTL_RESUME = 3;
    localparam int unsigned CTL_NIB_W  = 4;

    // Nibble base in the control word for each channel
    localparam int unsigned RTC_CTL_BASE = 8;
    localparam int unsigned GPT_CTL_BASE = 0;

    typedef struct packed {
        logic resume;
        logic en;
        logic load;
        logic auto_rl;
    } tmr_ctl_t;
endpackage

// File: rtl/tmr_prescaler.sv
// Module: tmr_prescaler
// Divides the clock by (limit + 1) while run is high. While run is low the
// divider is held at limit, so the first step comes limit+1 cycles after
// run rises. Assumes limit is stable while running (a change applies at
// the next reload of the divider).
module tmr_prescaler #(
    parameter int unsigned LIM_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [LIM_W-1:0] limit,
    output logic             step
);
    logic [LIM_W-1:0] div_q;

    assign step = run && (div_q == '0);

    // Purpose: count down from limit, reloading on each step or when idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q <= '1;
        end else if (!run || step) begin
            div_q <= limit;
        end else begin
            div_q <= div_q - 1'b1;
        end
    end
endmodule

// File: rtl/tmr_channel.sv
// Module: tmr_channel
// One down-counting timer: counter, reload value, prescaler limit, the
// auto-reload, enable and continue flags, and a registered one-cycle
// underflow pulse. Assumes at most one of the three write strobes per cycle
// and that a control write takes precedence over a same-cycle step.
module tmr_channel #(
    parameter int unsigned CNT_W = 32,
    parameter int unsigned LIM_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rld_we,
    input  logic               lim_we,
    input  logic               ctl_we,
    input  logic [CNT_W-1:0]   wdata,
    input  tmr_pkg::tmr_ctl_t  ctl,
    output logic [CNT_W-1:0]   cnt,
    output logic [CNT_W-1:0]   rld,
    output logic [CNT_W-1:0]   lim_ext,
    output logic               active,
    output logic               irq
);
    logic [LIM_W-1:0] lim_q;
    logic [CNT_W-1:0] cnt_q, rld_q;
    logic             auto_q, en_q, cont_q, irq_q, step;

    assign active  = en_q && cont_q;
    assign cnt     = cnt_q;
    assign rld     = rld_q;
    assign lim_ext = CNT_W'(lim_q);
    assign irq     = irq_q;

    tmr_prescaler #(.LIM_W(LIM_W)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (active),
        .limit (lim_q),
        .step  (step)
    );

    // Purpose: hold the prescaler limit, truncated to its own width.
    always_ff @(posedge clk) begin
        if (!rst_n)      lim_q <= '1;
        else if (lim_we) lim_q <= wdata[LIM_W-1:0];
    end

    // Purpose: hold the reload value; never touches the live counter.
    always_ff @(posedge clk) begin
        if (!rst_n)      rld_q <= '1;
        else if (rld_we) rld_q <= wdata;
    end

    // Purpose: count, detect underflow, and apply control commands.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '1;
            auto_q <= 1'b0;
            en_q   <= 1'b0;
            cont_q <= 1'b0;
            irq_q  <= 1'b0;
        end else begin
            irq_q <= 1'b0;
            if (step) begin
                if (cnt_q == '0) begin
                    irq_q <= 1'b1;
                    if (auto_q) cnt_q  <= rld_q;
                    else        cont_q <= 1'b0;
                end else begin
                    cnt_q <= cnt_q - 1'b1;
                end
            end
            if (ctl_we) begin
                auto_q <= ctl.auto_rl;
                en_q   <= ctl.en;
                if (ctl.load) begin
                    cnt_q  <= rld_q;
                    cont_q <= 1'b1;
                end
                if (ctl.resume) cont_q <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/tmr_dual_unit.sv
// Module: tmr_dual_unit (top)
// Decodes the register bus into two timer channels of different prescaler
// widths and returns read data combinationally. Assumes single-cycle write
// strobes and word addresses from tmr_pkg.
module tmr_dual_unit #(
    parameter int unsigned CNT_W     = 32,
    parameter int unsigned RTC_LIM_W = 8,
    parameter int unsigned GPT_LIM_W = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       bus_we,
    input  logic [tmr_pkg::ADDR_W-1:0] bus_addr,
    input  logic [CNT_W-1:0]           bus_wdata,
    output logic [CNT_W-1:0]           bus_rdata,
    output logic                       irq_rtc,
    output logic                       irq_gpt
);
    import tmr_pkg::*;

    logic             ctl_we;
    logic [CNT_W-1:0] cnt_q   [N_TMR];
    logic [CNT_W-1:0] rld_q   [N_TMR];
    logic [CNT_W-1:0] lim_q   [N_TMR];
    logic             act_q   [N_TMR];
    logic             irq_q   [N_TMR];

    assign ctl_we = bus_we && (bus_addr == REG_CTRL);

    for (genvar gi = 0; gi < N_TMR; gi++) begin : g_tmr
        localparam int unsigned          LW   = (gi == 0) ? RTC_LIM_W : GPT_LIM_W;
        localparam int unsigned          BASE = (gi == 0) ? RTC_CTL_BASE : GPT_CTL_BASE;
        localparam logic [ADDR_W-1:0]    A_CNT = (gi == 0) ? REG_RTC_CNT : REG_GPT_CNT;
        localparam logic [ADDR_W-1:0]    A_LIM = (gi == 0) ? REG_RTC_LIM : REG_GPT_LIM;

        tmr_ctl_t ctl_f;
        assign ctl_f = tmr_ctl_t'(bus_wdata[BASE +: CTL_NIB_W]);

        tmr_channel #(.CNT_W(CNT_W), .LIM_W(LW)) u_ch (
            .clk     (clk),
            .rst_n   (rst_n),
            .rld_we  (bus_we && (bus_addr == A_CNT)),
            .lim_we  (bus_we && (bus_addr == A_LIM)),
            .ctl_we  (ctl_we),
            .wdata   (bus_wdata),
            .ctl     (ctl_f),
            .cnt     (cnt_q[gi]),
            .rld     (rld_q[gi]),
            .lim_ext (lim_q[gi]),
            .active  (act_q[gi]),
            .irq     (irq_q[gi])
        );
    end

    assign irq_rtc = irq_q[0];
    assign irq_gpt = irq_q[1];

    // Purpose: select read data; count addresses return the live counter.
    always_comb begin
        unique case (bus_addr)
            REG_RTC_CNT: bus_rdata = cnt_q[0];
            REG_RTC_LIM: bus_rdata = lim_q[0];
            REG_GPT_CNT: bus_rdata = cnt_q[1];
            REG_GPT_LIM: bus_rdata = lim_q[1];
            default:     bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/tmr_dual_chk.sv
// Module: tmr_dual_chk
// Property checker for tmr_dual_unit, attached by bind below. Observes the
// interrupt outputs and each channel's counter, reload, limit and run state.
module tmr_dual_chk #(
    parameter int unsigned CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ctl_we,
    input logic             irq_rtc,
    input logic             irq_gpt,
    input logic [CNT_W-1:0] rtc_cnt,
    input logic [CNT_W-1:0] gpt_cnt,
    input logic [CNT_W-1:0] rtc_rld,
    input logic [CNT_W-1:0] gpt_rld,
    input logic [CNT_W-1:0] rtc_lim,
    input logic [CNT_W-1:0] gpt_lim,
    input logic             rtc_act,
    input logic             gpt_act
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    // R1: the cycle after reset is released, counters sit at all ones
    a_r1_reset_cnt: assert property (@(posedge clk)
        (rst_n && !$past(rst_n)) |-> (rtc_cnt == '1 && gpt_cnt == '1 && !irq_rtc && !irq_gpt));

    // R3: a pulse only follows a step taken with the counter at zero
    a_r3_rtc_zero: assert property (@(posedge clk) disable iff (!rst_n)
        irq_rtc |-> ($past(rtc_cnt) == '0));
    a_r3_gpt_zero: assert property (@(posedge clk) disable iff (!rst_n)
        irq_gpt |-> ($past(gpt_cnt) == '0));

    // R6: one-cycle pulse when the period is longer than a cycle
    a_r6_rtc_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_rtc && rtc_lim != '0) |=> !irq_rtc);
    a_r6_gpt_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_gpt && gpt_lim != '0) |=> !irq_gpt);

    // R9: a stopped timer's counter is frozen unless a control write occurs
    a_r9_rtc_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!rtc_act && !ctl_we) |=> $stable(rtc_cnt));
    a_r9_gpt_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!gpt_act && !ctl_we) |=> $stable(gpt_cnt));

    // R7: without a control write, a counter moves only by -1 or to reload
    a_r7_rtc_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(rtc_cnt) && !$past(ctl_we)) |->
        (rtc_cnt == $past(rtc_cnt) - ONE || rtc_cnt == $past(rtc_rld)));
    a_r7_gpt_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(gpt_cnt) && !$past(ctl_we)) |->
        (gpt_cnt == $past(gpt_cnt) - ONE || gpt_cnt == $past(gpt_rld)));
endmodule

bind tmr_dual_unit tmr_dual_chk #(.CNT_W(CNT_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .ctl_we  (ctl_we),
    .irq_rtc (irq_rtc),
    .irq_gpt (irq_gpt),
    .rtc_cnt (cnt_q[0]),
    .gpt_cnt (cnt_q[1]),
    .rtc_rld (rld_q[0]),
    .gpt_rld (rld_q[1]),
    .rtc_lim (lim_q[0]),
    .gpt_lim (lim_q[1]),
    .rtc_act (act_q[0]),
    .gpt_act (act_q[1])
);

// File: tb/sim_tmr_dual_unit.sv
// Bench for tmr_dual_unit: a vector table of timer programs with expected
// latencies, then directed tests for reset and corner cases.
module sim_tmr_dual_unit;
    localparam int CLK_PERIOD = 10;
    localparam int MAX_WAIT   = 5000;

    typedef struct packed {
        int sel;   // 0 = real-time, 1 = general-purpose
        int rld;
        int lim;
        int exp;   // expected cycles: (rld+1)*(lim+1)
    } vec_t;

    localparam vec_t VEC [5] = '{
        '{0, 3, 0, 4},
        '{0, 2, 4, 15},
        '{1, 5, 2, 18},
        '{1, 0, 9, 10},
        '{0, 7, 3, 32}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_rtc, irq_gpt;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    tmr_dual_unit u0 (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_rtc(irq_rtc), .irq_gpt(irq_gpt)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    function automatic logic pick(input int sel);
        return (sel == 0) ? irq_rtc : irq_gpt;
    endfunction

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired actual=0x%08h expected=0x%08h", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        int n;
        bit other, hit;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset values
        rd(3'd0, v); chk(v == 32'hFFFF_FFFF, "R1 rtc count", v, 32'hFFFF_FFFF);
        rd(3'd2, v); chk(v == 32'hFFFF_FFFF, "R1 gpt count", v, 32'hFFFF_FFFF);
        rd(3'd1, v); chk(v == 32'h0000_00FF, "R1 rtc limit", v, 32'hFF);
        rd(3'd3, v); chk(v == 32'h0000_FFFF, "R1 gpt limit", v, 32'hFFFF);
        chk(!irq_rtc && !irq_gpt, "R1 irqs low", {30'd0, irq_rtc, irq_gpt}, 0);
        wr(3'd4, 32'h0000_0202);   // load both, no enable: reload reset value
        repeat (5) @(negedge clk);
        rd(3'd0, v); chk(v == 32'hFFFF_FFFF, "R1 rtc reload", v, 32'hFFFF_FFFF);
        rd(3'd2, v); chk(v == 32'hFFFF_FFFF, "R1 gpt reload", v, 32'hFFFF_FFFF);

        // R2: limit truncation
        wr(3'd1, 32'hFFFF_FF12); rd(3'd1, v); chk(v == 32'h12, "R2 rtc limit 8b", v, 32'h12);
        wr(3'd3, 32'hABCD_1234); rd(3'd3, v); chk(v == 32'h1234, "R2 gpt limit 16b", v, 32'h1234);

        // R3 R4 R6 R10: table walk
        for (int i = 0; i < 5; i++) begin
            int base;
            base = (VEC[i].sel == 0) ? 8 : 0;
            wr(3'(VEC[i].sel * 2 + 1), 32'(VEC[i].lim));
            wr(3'(VEC[i].sel * 2), 32'(VEC[i].rld));
            wr(3'd4, 32'h7 << base);
            n = 0; other = 0; hit = 0;
            while (!hit && n < MAX_WAIT) begin
                @(negedge clk); n++;
                if (pick(1 - VEC[i].sel)) other = 1;
                if (pick(VEC[i].sel)) hit = 1;
            end
            chk(n == VEC[i].exp, "R3 first latency", 32'(n), 32'(VEC[i].exp));
            @(negedge clk); n = 1;
            chk(!pick(VEC[i].sel), "R6 pulse width", {31'd0, pick(VEC[i].sel)}, 0);
            while (!pick(VEC[i].sel) && n < MAX_WAIT) begin
                @(negedge clk); n++;
                if (pick(1 - VEC[i].sel)) other = 1;
            end
            chk(n == VEC[i].exp, "R4 reload period", 32'(n), 32'(VEC[i].exp));
            chk(!other, "R10 other timer quiet", {31'd0, other}, 0);
            wr(3'd4, 32'h0);
        end

        // R5: single shot on the general-purpose timer
        wr(3'd3, 32'd1); wr(3'd2, 32'd2);
        wr(3'd4, 32'h0000_0006);
        n = 0;
        while (!irq_gpt && n < MAX_WAIT) begin @(negedge clk); n++; end
        chk(n == 6, "R5 single shot latency", 32'(n), 6);
        hit = 0;
        repeat (30) begin @(negedge clk); if (irq_gpt) hit = 1; end
        chk(!hit, "R5 no second pulse", {31'd0, hit}, 0);
        rd(3'd2, v); chk(v == 0, "R5 counter holds zero", v, 0);

        // R9: enable without continue latch keeps it frozen
        wr(3'd4, 32'h0000_0004);
        hit = 0;
        repeat (20) begin @(negedge clk); if (irq_gpt) hit = 1; end
        chk(!hit, "R9 enable only no pulse", {31'd0, hit}, 0);

        // R8: resume without load from zero -> pulse after (0+1)*(1+1)
        wr(3'd4, 32'h0000_000C);
        n = 0;
        while (!irq_gpt && n < MAX_WAIT) begin @(negedge clk); n++; end
        chk(n == 2, "R8 resume latency", 32'(n), 2);

        // R9: load without enable keeps the count frozen
        wr(3'd2, 32'd50);
        wr(3'd4, 32'h0000_0002);
        rd(3'd2, v); chk(v == 50, "R9 loaded value", v, 50);
        repeat (10) @(negedge clk);
        rd(3'd2, v); chk(v == 50, "R9 frozen without enable", v, 50);

        // R7: reload write does not touch the counter until the next load
        wr(3'd2, 32'd77);
        rd(3'd2, v); chk(v == 50, "R7 counter untouched", v, 50);
        wr(3'd4, 32'h0000_0002);
        rd(3'd2, v); chk(v == 77, "R7 applied on load", v, 77);

        // R11: live counter read on the real-time timer, limit 0
        wr(3'd4, 32'h0);
        wr(3'd1, 32'd0); wr(3'd0, 32'd10);
        wr(3'd4, 32'h0000_0600);
        rd(3'd0, v); chk(v == 10, "R11 count at start", v, 10);
        repeat (3) @(negedge clk);
        rd(3'd0, v); chk(v == 7, "R11 count after three steps", v, 7);
        wr(3'd4, 32'h0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule